// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. An external divisor supplies a clock enable at sixteen times the bit rate, and the receiver counts these enables to place one sample at the centre of each bit. A configuration input sets the character length (five to eight data bits) and the parity mode (none, even or odd). A start edge is confirmed at the centre of the start bit before a character is assembled.

Each finished character goes into a receive queue together with three flags of its own: parity error, framing error and break. The queue holds 64 entries in FIFO mode and a single entry in holding-register mode. The host sees the oldest entry at the output at all times and removes it with a one-cycle read strobe. A status word gives data-ready and four sticky error bits: overrun, parity, framing and break. A one-cycle line-status read strobe clears the error bits. A single request output is high while any status bit is set.

Top module: `serial_rx_top`

## Requirements
- R1: The receiver advances only on cycles where `tick16` is high. Each bit is sampled once, on the 8th of its 16 ticks. With `tick16` held low, a complete frame on `rxd` produces no entry.
- R2: Data bits arrive least significant bit first. `cfg_len` 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, and `rd_data` bits above the selected length read zero.
- R3: With `cfg_par_en`=1, one parity bit follows the data. It is even parity when `cfg_par_odd`=0 and odd parity when `cfg_par_odd`=1. A mismatch sets `rd_err[0]` for that entry and `status[2]`.
- R4: A low level that is high again when the start bit is sampled at mid-bit is a false start. It is discarded, no entry is made, and the receiver goes back to idle.
- R5: A first stop bit sampled low, on a character that is not a break, sets `rd_err[1]` for that entry and `status[3]`. The receiver then waits for the line to go high before it looks for a new start.
- R6: A line that is low for the whole character (start, data, parity if enabled, and stop) loads one entry with data zero, `rd_err`=3'b100 (parity and framing clear) and sets `status[4]`. No further entry is made until the line returns high.
- R7: In FIFO mode (`cfg_fifo_en`=1) up to 64 entries are held and returned in arrival order. `status[0]` is high exactly while the queue is not empty.
- R8: In holding-register mode (`cfg_fifo_en`=0) the queue holds one entry. The mode is changed only while the queue is empty.
- R9: A character that completes while the queue is full is dropped. The stored entries are kept and `status[1]` (overrun) is set.
- R10: A pulse on `lsr_rd_stb` clears `status[4:1]` on the next clock and leaves `status[0]` unchanged. If an error arrives on the same clock as the pulse, the new error is kept.
- R11: After reset, `status` is zero, `irq` is low and the queue is empty.
- R12: `irq` is high exactly when some bit of `status` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Clock enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 means 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_fifo_en | input | 1 | 1 gives a 64-entry queue, 0 a single holding entry |
| rd_data_stb | input | 1 | Removes the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_err | output | 3 | Flags of the oldest entry: {break, framing, parity} |
| lsr_rd_stb | input | 1 | Line-status read; clears the error bits |
| status | output | 5 | {break, framing, parity, overrun, data ready} |
| irq | output | 1 | Receive or line-status request |

## Verification
The bench builds the receiver with its default 16-tick oversampling and a 64-entry queue, and it applies a tick on every fourth clock. These values keep a frame short enough that every data value at five bits, and a spread of values at each of the other lengths and parity modes, fit within the run. With a 64-entry queue the bench can fill it completely, push one more character to force an overrun, and then drain it while checking the order. The single-entry mode, false starts, framing errors and a full break are each driven at the line and checked at the ports.

// File: rtl/srx_pkg.sv
// Package: shared constants and types for the serial receiver.
// Assumes characters are at most RX_DW bits wide and at least RX_DW-3 bits.
package srx_pkg;
    localparam int RX_DW   = 8;
    localparam int MIN_LEN = RX_DW - 3;

    // Receiver phase within one character.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    // One queued character with its own error flags.
    typedef struct packed {
        logic             brk;
        logic             frm;
        logic             par;
        logic [RX_DW-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/srx_deframer.sv
// Module: srx_deframer
// Turns the synchronised serial line into characters with error flags.
// It samples once per bit at mid-bit and counts OVS ticks per bit.
// Assumes: tick16 is a one-cycle enable; the configuration is stable
// while a character is being received.
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick16,
    input  logic      rxd,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    output logic      char_vld,
    output rx_entry_t char_q
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(RX_DW + 1);
    localparam logic [CW-1:0] HALF_C = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] FULL_C = CW'(OVS - 1);

    logic             rx_m, rx_s;
    rx_state_t        state;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bidx;
    logic [RX_DW-1:0] shreg;
    logic             par_acc, par_err, any_one;
    logic [BW-1:0]    nbits, shamt;
    logic [RX_DW-1:0] aligned;

    // Two-stage synchroniser for the asynchronous line; it resets to idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
        end
    end

    // Works out the data length and moves the shifted bits down to bit 0.
    always_comb begin
        nbits   = BW'(MIN_LEN) + BW'(cfg_len);
        shamt   = BW'(RX_DW) - nbits;
        aligned = shreg >> shamt;
    end

    // Bit-phase state machine: confirms the start bit, collects the bits,
    // checks the stop bit and hands out the character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            par_err  <= 1'b0;
            any_one  <= 1'b0;
            char_vld <= 1'b0;
            char_q   <= '0;
        end else begin
            char_vld <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tick16 && !rx_s) begin
                        state   <= ST_START;
                        cnt     <= CW'(1);
                        bidx    <= '0;
                        shreg   <= '0;
                        par_acc <= 1'b0;
                        par_err <= 1'b0;
                        any_one <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick16) begin
                        if (cnt == HALF_C) begin
                            cnt   <= '0;
                            state <= rx_s ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (tick16) begin
                        if (cnt == FULL_C) begin
                            cnt     <= '0;
                            shreg   <= {rx_s, shreg[RX_DW-1:1]};
                            par_acc <= par_acc ^ rx_s;
                            any_one <= any_one | rx_s;
                            bidx    <= bidx + BW'(1);
                            if (bidx == nbits - BW'(1)) begin
                                state <= cfg_par_en ? ST_PAR : ST_STOP;
                            end
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_PAR: begin
                    if (tick16) begin
                        if (cnt == FULL_C) begin
                            cnt     <= '0;
                            par_err <= par_acc ^ rx_s ^ cfg_par_odd;
                            any_one <= any_one | rx_s;
                            state   <= ST_STOP;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (tick16) begin
                        if (cnt == FULL_C) begin
                            cnt      <= '0;
                            char_vld <= 1'b1;
                            if (!any_one && !rx_s) begin
                                char_q <= '{brk: 1'b1, frm: 1'b0, par: 1'b0, data: '0};
                            end else begin
                                char_q <= '{brk: 1'b0, frm: !rx_s,
                                            par: cfg_par_en & par_err, data: aligned};
                            end
                            state <= rx_s ? ST_IDLE : ST_HOLD;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (rx_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A start level that is high again at mid-bit returns to idle without an entry.
    assert_false_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && tick16 && cnt == HALF_C && rx_s) |=> (state == ST_IDLE && !char_vld));

    // Without a tick the bit counter and the phase stay put.
    assert_tick_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && state != ST_IDLE && state != ST_HOLD) |=> ($stable(cnt) && $stable(state)));

    // After a break entry the receiver waits for the line to go high.
    assert_break_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && char_q.brk) |-> (state == ST_HOLD && char_q.data == '0));

    // After a low stop bit the receiver does not hunt for a start until the line is high.
    assert_low_stop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && char_q.frm) |-> (state == ST_HOLD));
endmodule

// File: rtl/srx_fifo.sv
// Module: srx_fifo
// Circular receive queue whose oldest entry is always shown at the output.
// In single mode its capacity drops to one entry.
// Assumes: pushes are dropped when full (the caller flags overrun); pops
// on an empty queue are ignored; the mode changes only while empty.
module srx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         single_mode,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    // Capacity check against the count held at the start of the cycle.
    always_comb begin
        full    = single_mode ? (count != '0) : (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Storage write; the array needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Occupancy never goes past the array depth.
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // In single mode the occupancy never goes past one.
    assert_single_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && !empty && push && !pop) |=> (count == $past(count)));

    // A push into a full queue leaves the occupancy unchanged.
    assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/srx_status.sv
// Module: srx_status
// Sticky line-status bits and the request output.
// Assumes: char_vld pulses for one cycle per finished character and
// q_full reflects the queue before that cycle's push.
module srx_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_vld,
    input  logic       ent_par,
    input  logic       ent_frm,
    input  logic       ent_brk,
    input  logic       q_full,
    input  logic       q_empty,
    input  logic       lsr_rd,
    output logic [4:0] status,
    output logic       irq
);
    logic [3:0] err_q, err_d;   // {brk, frm, par, ovr}

    // Next error bits: a read clears them, and new events are set on top.
    always_comb begin
        err_d = lsr_rd ? 4'b0000 : err_q;
        if (char_vld && q_full) begin
            err_d[0] = 1'b1;
        end else if (char_vld) begin
            err_d[1] = err_d[1] | ent_par;
            err_d[2] = err_d[2] | ent_frm;
            err_d[3] = err_d[3] | ent_brk;
        end
    end

    // Error bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    // Status word and request output.
    always_comb begin
        status = {err_q, !q_empty};
        irq    = |status;
    end

    // A status read with no new character leaves every error bit clear.
    assert_lsr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !char_vld) |=> (status[4:1] == 4'b0000));

    // A character arriving into a full queue raises overrun.
    assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && q_full) |=> status[1]);
endmodule

// File: rtl/serial_rx_top.sv
// Module: serial_rx_top
// Asynchronous serial receiver with a per-entry error queue and line status.
// Assumes: tick16 comes from an external baud divisor at 16x the bit rate
// (OVS ticks per bit); the configuration changes only while idle and empty.
module serial_rx_top
    import srx_pkg::*;
#(
    parameter int OVS        = 16,
    parameter int FIFO_DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             rxd,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_fifo_en,
    input  logic             rd_data_stb,
    output logic [RX_DW-1:0] rd_data,
    output logic [2:0]       rd_err,
    input  logic             lsr_rd_stb,
    output logic [4:0]       status,
    output logic             irq
);
    localparam int EW = $bits(rx_entry_t);

    logic          char_vld;
    rx_entry_t     char_q;
    logic [EW-1:0] head_bits;
    rx_entry_t     head_e;
    logic          q_full, q_empty;

    srx_deframer #(.OVS(OVS)) u_deframer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick16     (tick16),
        .rxd        (rxd),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .char_vld   (char_vld),
        .char_q     (char_q)
    );

    srx_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_mode(!cfg_fifo_en),
        .push       (char_vld),
        .push_data  (char_q),
        .pop        (rd_data_stb),
        .head       (head_bits),
        .full       (q_full),
        .empty      (q_empty)
    );

    srx_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .char_vld(char_vld),
        .ent_par (char_q.par),
        .ent_frm (char_q.frm),
        .ent_brk (char_q.brk),
        .q_full  (q_full),
        .q_empty (q_empty),
        .lsr_rd  (lsr_rd_stb),
        .status  (status),
        .irq     (irq)
    );

    // Splits the oldest entry into its data and flag fields.
    always_comb begin
        head_e  = rx_entry_t'(head_bits);
        rd_data = head_e.data;
        rd_err  = {head_e.brk, head_e.frm, head_e.par};
    end

    // Data-ready follows the queue: it is high while an entry is waiting.
    assert_ready_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !q_full && !rd_data_stb) |=> status[0]);

    // The request tracks the status word.
    assert_irq_tracks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != 5'b0));
endmodule

// File: tb/serial_rx_top_tb.sv
module serial_rx_top_tb;
    localparam int TDIV = 4;
    localparam int TPB  = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic [1:0] tdiv = '0;
    logic       tick16;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_fifo_en = 1'b1;
    logic       rd_data_stb = 1'b0, lsr_rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [4:0] status;
    logic       irq;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) tdiv <= (tdiv == 2'(TDIV - 1)) ? 2'd0 : tdiv + 2'd1;
    assign tick16 = tick_en && (tdiv == 2'(TDIV - 1));

    serial_rx_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_fifo_en(cfg_fifo_en), .rd_data_stb(rd_data_stb), .rd_data(rd_data),
        .rd_err(rd_err), .lsr_rd_stb(lsr_rd_stb), .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (TPB) @(negedge clk);
    endtask

    // pm: 0 none, 1 even, 2 odd
    task automatic send(input logic [7:0] v, input int nb, input int pm,
                        input bit badpar, input bit stop_lo);
        logic p;
        p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= v[i];
        if (pm == 2) p = ~p;
        if (badpar) p = ~p;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(v[i]);
        if (pm != 0) drive_bit(p);
        drive_bit(!stop_lo);
        drive_bit(1'b1);
    endtask

    task automatic set_fmt(input int nb, input int pm);
        cfg_len     = 2'(nb - 5);
        cfg_par_en  = (pm != 0);
        cfg_par_odd = (pm == 2);
    endtask

    task automatic pop();
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic lsr_read();
        lsr_rd_stb = 1'b1;
        @(negedge clk);
        lsr_rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v, mask;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 status after reset", 16'(status), 16'h0);
        chk("R11 irq after reset", 16'(irq), 16'h0);

        // R1: a frame with no ticks leaves nothing behind
        tick_en = 1'b0;
        set_fmt(8, 0);
        send(8'hA5, 8, 0, 1'b0, 1'b0);
        chk("R1 no tick no entry", 16'(status), 16'h0);
        tick_en = 1'b1;
        repeat (TPB) @(negedge clk);

        // R2/R3: sweep over lengths and parity modes
        for (int nb = 5; nb <= 8; nb++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 4; k++) begin
                    bit bp;
                    mask = 8'((16'd1 << nb) - 16'd1);
                    v    = 8'((k * 73 + nb * 29 + pm * 11 + 5)) & mask;
                    bp   = (pm != 0) && (k == 3);
                    set_fmt(nb, pm);
                    send(v, nb, pm, bp, 1'b0);
                    chk("R2 data value", 16'(rd_data), 16'(v));
                    chk("R3 entry flags", 16'(rd_err), 16'({2'b00, bp}));
                    chk("R3 status parity", 16'(status[2]), 16'(bp));
                    chk("R7 data ready", 16'(status[0]), 16'h1);
                    chk("R12 irq set", 16'(irq), 16'h1);
                    pop();
                    lsr_read();
                    chk("R10 status cleared", 16'(status), 16'h0);
                end
            end
        end

        // R2: every five-bit value
        set_fmt(5, 0);
        for (int i = 0; i < 32; i++) begin
            send(8'(i), 5, 0, 1'b0, 1'b0);
            chk("R2 five-bit sweep", 16'({rd_err, rd_data}), 16'(i));
            pop();
        end
        chk("R7 empty after sweep", 16'(status), 16'h0);

        // R4: false start
        rxd = 1'b0;
        repeat (4 * TDIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * TPB) @(negedge clk);
        chk("R4 false start ignored", 16'(status), 16'h0);

        // R5: framing error
        set_fmt(8, 0);
        send(8'h3C, 8, 0, 1'b0, 1'b1);
        chk("R5 framing data", 16'(rd_data), 16'h3C);
        chk("R5 framing flags", 16'(rd_err), 16'h2);
        chk("R5 framing status", 16'(status), 16'h09);
        pop();
        lsr_read();

        // R6: break with even parity, 8 bits
        set_fmt(8, 1);
        rxd = 1'b0;
        repeat (13 * TPB) @(negedge clk);
        chk("R6 break data", 16'(rd_data), 16'h0);
        chk("R6 break flags", 16'(rd_err), 16'h4);
        chk("R6 break status", 16'(status), 16'h11);
        rxd = 1'b1;
        repeat (TPB) @(negedge clk);
        pop();
        chk("R6 single break entry", 16'(status[0]), 16'h0);
        lsr_read();
        send(8'h5A, 8, 1, 1'b0, 1'b0);
        chk("R6 receive after break", 16'({rd_err, rd_data}), 16'h05A);
        pop();

        // R8/R9/R10: holding-register mode overrun
        cfg_fifo_en = 1'b0;
        set_fmt(8, 0);
        send(8'h11, 8, 0, 1'b0, 1'b0);
        send(8'h22, 8, 0, 1'b0, 1'b0);
        chk("R8 holding keeps first", 16'(rd_data), 16'h11);
        chk("R9 overrun status", 16'(status), 16'h03);
        lsr_read();
        chk("R10 ready kept after clear", 16'(status), 16'h01);
        pop();
        chk("R8 single entry only", 16'(status), 16'h0);
        chk("R12 irq clear", 16'(irq), 16'h0);

        // R7/R9: fill the 64-entry queue, overrun, then drain
        cfg_fifo_en = 1'b1;
        set_fmt(5, 0);
        for (int i = 0; i < 64; i++) send(8'((i * 7) & 31), 5, 0, 1'b0, 1'b0);
        chk("R7 full no overrun", 16'(status), 16'h01);
        send(8'h1F, 5, 0, 1'b0, 1'b0);
        chk("R9 fifo overrun", 16'(status), 16'h03);
        for (int i = 0; i < 64; i++) begin
            chk("R7 fifo order", 16'(rd_data), 16'((i * 7) & 31));
            pop();
        end
        chk("R9 dropped char absent", 16'(status[0]), 16'h0);
        lsr_read();
        chk("R10 final clear", 16'(status), 16'h0);

        finish_run();
    end
endmodule